// File: doc/BRIEF.md
# Boost Converter Fault Supervisor

This block is the digital protection supervisor of a boost LED backlight controller. It takes comparator results that are already synchronous to its clock: over-voltage, LED over-current, hard inductor over-current and feedback-at-maximum. It also takes a soft-start-done flag, a pair of supply start and stop flags, the standby enable, the PWM dimming input and a one-cycle tick per switching period. From these it decides whether the boost gate may switch, whether the dimming switch must be forced off, and whether the converter has entered a latched fault.

Each fault is qualified by counting switching ticks, not clock cycles. Three faults latch after an unbroken run of four ticks. Feedback-at-maximum is qualified only after soft start has finished and only while PWM is high. Once it is qualified it starts a second, longer timer that watches the feedback flag alone. That timer takes the place of an analog capacitor timer, and its length is a parameter. A latched fault stays until the standby input is pulled low.

Top module: `boost_fault_supervisor`

## Requirements
- R1: While ovpFlag is high, gateEn is low and dimForceLow is high in the same cycle, with no tick needed.
- R2: ovpFlag high on four consecutive cycleTick pulses latches the fault; three pulses do not.
- R3: ledOcFlag high on four consecutive cycleTick pulses latches the fault.
- R4: hardOcFlag high on four consecutive cycleTick pulses latches the fault even while gateEn is low because pwmIn is low.
- R5: A tick on which a fault flag is low clears that flag's run count, so runs of three broken by one clean tick never latch.
- R6: Feedback-at-maximum is counted only on ticks where ssDone, fbMaxFlag and pwmIn are all high; four such consecutive ticks start the secondary timer.
- R7: Once the secondary timer is running, only fbMaxFlag is watched. CP_LIMIT further ticks with it high latch the fault (CP_LIMIT-1 do not). A tick with it low stops and clears the timer.
- R8: Not latched: faultLatched is 0 and failN is 1. Latched: faultLatched is 1, failN is 0, gateEn is 0 and dimForceLow is 1.
- R9: The latch survives fault flags clearing and supply stop/start. It is cleared only by stbIn low.
- R10: The converter runs after stbIn is high and a uvloStart pulse is seen. A uvloStop pulse halts it, and it stays halted until the next uvloStart. While running and unfaulted, gateEn follows pwmIn and dimForceLow is 0. While halted, gateEn is 0 and dimForceLow is 1.
- R11: While stbIn is low or the supply is halted, all run counts and the secondary timer are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stbIn | input | 1 | Standby enable; low clears the latch |
| uvloStart | input | 1 | Supply rose above the upper threshold |
| uvloStop | input | 1 | Supply fell below the lower threshold |
| pwmIn | input | 1 | PWM dimming input |
| cycleTick | input | 1 | One-cycle pulse per switching period |
| ssDone | input | 1 | Soft start complete |
| ovpFlag | input | 1 | Output over-voltage comparator |
| ledOcFlag | input | 1 | LED over-current comparator |
| hardOcFlag | input | 1 | Inductor current above the hard limit |
| fbMaxFlag | input | 1 | Error amplifier output at maximum |
| gateEn | output | 1 | Boost gate switching allowed |
| dimForceLow | output | 1 | Force the dimming switch off |
| faultLatched | output | 1 | Latched-off state |
| failN | output | 1 | Active-low fail indicator |

## Verification
A run count that is not cleared shows up as a latch that fires early. One or two stray ticks after a broken run, or after a standby or supply cycle, raise faultLatched and drop failN within two clocks of the tick. A count that clears too eagerly shows up the other way: faultLatched stays low after the fourth tick. A secondary timer that is off by one, or that does not stop when feedback-at-maximum drops, moves the latch by exactly one tick, so the bench probes both CP_LIMIT-1 and CP_LIMIT ticks. A wrong state register shows at once on gateEn and dimForceLow, because both are decoded from it in the same cycle.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  // indices of the fixed-run faults
  localparam int FIX_OVP    = 0;
  localparam int FIX_LEDOC  = 1;
  localparam int FIX_HARDOC = 2;
  localparam int FIX_COUNT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClear;
    logic tickEn;
    logic fbQualEn;
  } bfsStrobe_t;
endpackage

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int RUN_LEN  = 4,
  parameter int CP_LIMIT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bfsStrobe_t           strobe,
  input  logic [FIX_COUNT-1:0] fixFlags,
  input  logic                 fbMaxFlag,
  input  logic                 pwmIn,
  output logic [FIX_COUNT-1:0] fixTrip,
  output logic                 fbTrip
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam int TW = $clog2(CP_LIMIT + 1);

  // fixed-run fault counters, one per flag
  for (genvar i = 0; i < FIX_COUNT; i++) begin : g_fix
    logic [CW-1:0] runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobe.holdClear) begin
        runCnt <= '0;
      end else if (strobe.tickEn) begin
        if (!fixFlags[i])                  runCnt <= '0;
        else if (runCnt != CW'(RUN_LEN))   runCnt <= runCnt + CW'(1);
      end
    end

    assign fixTrip[i] = (runCnt == CW'(RUN_LEN));

    assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
      runCnt <= CW'(RUN_LEN));

    // R5: a clean tick clears the run
    assert_run_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.tickEn && !fixFlags[i]) |=> (runCnt == '0));
  end

  // feedback-at-maximum: qualification run, then secondary timer
  logic [CW-1:0] qualCnt;
  logic [TW-1:0] cpTimer;
  logic          timerOn;
  logic          qualNow;

  assign qualNow = strobe.fbQualEn && fbMaxFlag && pwmIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
      cpTimer <= '0;
      timerOn <= 1'b0;
    end else if (strobe.holdClear) begin
      qualCnt <= '0;
      cpTimer <= '0;
      timerOn <= 1'b0;
    end else if (strobe.tickEn) begin
      if (timerOn) begin
        if (!fbMaxFlag) begin
          timerOn <= 1'b0;
          cpTimer <= '0;
          qualCnt <= '0;
        end else if (cpTimer != TW'(CP_LIMIT)) begin
          cpTimer <= cpTimer + TW'(1);
        end
      end else if (qualNow) begin
        qualCnt <= qualCnt + CW'(1);
        if (qualCnt == CW'(RUN_LEN - 1)) timerOn <= 1'b1;
      end else begin
        qualCnt <= '0;
      end
    end
  end

  assign fbTrip = timerOn && (cpTimer == TW'(CP_LIMIT));

  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpTimer <= TW'(CP_LIMIT));

  // R6: no timer start without a qualifying tick
  assert_fb_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!timerOn && !(strobe.tickEn && qualNow)) |=> !timerOn);

  // R11: hold keeps the timer stopped
  assert_hold_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdClear |=> (!timerOn && cpTimer == '0));
endmodule

// File: rtl/bfs_control.sv
module bfs_control
  import bfs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stbIn,
  input  logic                 uvloStart,
  input  logic                 uvloStop,
  input  logic                 pwmIn,
  input  logic                 cycleTick,
  input  logic                 ssDone,
  input  logic                 ovpFlag,
  input  logic [FIX_COUNT-1:0] fixTrip,
  input  logic                 fbTrip,
  output bfsStrobe_t           strobe,
  output logic                 gateEn,
  output logic                 dimForceLow,
  output logic                 faultLatched,
  output logic                 failN
);
  logic      supplyOk;
  supState_t state, stateNext;
  logic      anyTrip;

  // supply hysteresis from separate start/stop flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          supplyOk <= 1'b0;
    else if (uvloStop)  supplyOk <= 1'b0;
    else if (uvloStart) supplyOk <= 1'b1;
  end

  assign anyTrip = (|fixTrip) || fbTrip;

  always_comb begin
    stateNext = state;
    if (!stbIn) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (supplyOk) stateNext = ST_RUN;
        ST_RUN: begin
          if (anyTrip)        stateNext = ST_LATCH;
          else if (!supplyOk) stateNext = ST_IDLE;
        end
        ST_LATCH: stateNext = ST_LATCH;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.holdClear = (state != ST_RUN);
  assign strobe.tickEn    = cycleTick;
  assign strobe.fbQualEn  = ssDone;

  assign gateEn       = (state == ST_RUN) && pwmIn && !ovpFlag;
  assign dimForceLow  = (state != ST_RUN) || ovpFlag;
  assign faultLatched = (state == ST_LATCH);
  assign failN        = !faultLatched;

  assert_ovp_blocks_R1: assert property (@(posedge clk) disable iff (!rstN)
    ovpFlag |-> (!gateEn && dimForceLow));

  assert_latched_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!gateEn && dimForceLow && !failN));

  assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && stbIn) |=> faultLatched);

  assert_stb_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stbIn |=> !faultLatched);

  assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (uvloStop && !faultLatched) |=> ##1 !gateEn);
endmodule

// File: rtl/boost_fault_supervisor.sv
module boost_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int RUN_LEN  = 4,
  parameter int CP_LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic stbIn,
  input  logic uvloStart,
  input  logic uvloStop,
  input  logic pwmIn,
  input  logic cycleTick,
  input  logic ssDone,
  input  logic ovpFlag,
  input  logic ledOcFlag,
  input  logic hardOcFlag,
  input  logic fbMaxFlag,
  output logic gateEn,
  output logic dimForceLow,
  output logic faultLatched,
  output logic failN
);
  bfsStrobe_t           strobe;
  logic [FIX_COUNT-1:0] fixFlags;
  logic [FIX_COUNT-1:0] fixTrip;
  logic                 fbTrip;

  always_comb begin
    fixFlags             = '0;
    fixFlags[FIX_OVP]    = ovpFlag;
    fixFlags[FIX_LEDOC]  = ledOcFlag;
    fixFlags[FIX_HARDOC] = hardOcFlag;
  end

  bfs_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .stbIn        (stbIn),
    .uvloStart    (uvloStart),
    .uvloStop     (uvloStop),
    .pwmIn        (pwmIn),
    .cycleTick    (cycleTick),
    .ssDone       (ssDone),
    .ovpFlag      (ovpFlag),
    .fixTrip      (fixTrip),
    .fbTrip       (fbTrip),
    .strobe       (strobe),
    .gateEn       (gateEn),
    .dimForceLow  (dimForceLow),
    .faultLatched (faultLatched),
    .failN        (failN)
  );

  bfs_datapath #(
    .RUN_LEN  (RUN_LEN),
    .CP_LIMIT (CP_LIMIT)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fixFlags  (fixFlags),
    .fbMaxFlag (fbMaxFlag),
    .pwmIn     (pwmIn),
    .fixTrip   (fixTrip),
    .fbTrip    (fbTrip)
  );
endmodule

// File: tb/boost_fault_supervisor_bench.sv
`timescale 1ns/1ps
module boost_fault_supervisor_bench;
  localparam int CP_LIMIT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stbIn = 1'b0, uvloStart = 1'b0, uvloStop = 1'b0, pwmIn = 1'b0;
  logic cycleTick = 1'b0, ssDone = 1'b0, ovpFlag = 1'b0, ledOcFlag = 1'b0;
  logic hardOcFlag = 1'b0, fbMaxFlag = 1'b0;
  logic gateEn, dimForceLow, faultLatched, failN;

  always #2 clk = ~clk;

  boost_fault_supervisor #(.RUN_LEN(4), .CP_LIMIT(CP_LIMIT)) u_boost_fault_supervisor (
    .clk(clk), .rstN(rstN), .stbIn(stbIn), .uvloStart(uvloStart), .uvloStop(uvloStop),
    .pwmIn(pwmIn), .cycleTick(cycleTick), .ssDone(ssDone), .ovpFlag(ovpFlag),
    .ledOcFlag(ledOcFlag), .hardOcFlag(hardOcFlag), .fbMaxFlag(fbMaxFlag),
    .gateEn(gateEn), .dimForceLow(dimForceLow), .faultLatched(faultLatched), .failN(failN)
  );

  typedef struct {
    string tag;
    logic  gate;
    logic  dim;
    logic  lat;
  } expItem_t;

  expItem_t expQ[$];
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // driver side
  task automatic expectOut(input string tag, input logic g, input logic d, input logic l);
    expItem_t it;
    it.tag = tag; it.gate = g; it.dim = d; it.lat = l;
    expQ.push_back(it);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic doTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) cycleTick = 1'b1;
      @(negedge clk) cycleTick = 1'b0;
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) uvloStart = 1'b1;
    @(negedge clk) uvloStart = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) uvloStop = 1'b1;
    @(negedge clk) uvloStop = 1'b0;
  endtask

  task automatic bringUp();
    @(negedge clk) stbIn = 1'b1;
    pulseStart();
    settle();
  endtask

  task automatic clearLatch();
    @(negedge clk) stbIn = 1'b0;
    settle();
  endtask

  // monitor side: compare after each rising edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (gateEn !== it.gate || dimForceLow !== it.dim ||
            faultLatched !== it.lat || failN !== !it.lat) begin
          errors++;
          $display("FAIL %s: got gate=%b dim=%b lat=%b failN=%b, expected gate=%b dim=%b lat=%b failN=%b",
                   it.tag, gateEn, dimForceLow, faultLatched, failN,
                   it.gate, it.dim, it.lat, !it.lat);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    expectOut("R8 reset idle", 1'b0, 1'b1, 1'b0);
    settle();
    // R10: standby high without a supply start stays halted
    @(negedge clk) stbIn = 1'b1; pwmIn = 1'b1;
    settle();
    expectOut("R10 no start yet", 1'b0, 1'b1, 1'b0);
    pulseStart();
    settle();
    expectOut("R10 running follows pwm", 1'b1, 1'b0, 1'b0);
    @(negedge clk) pwmIn = 1'b0;
    expectOut("R10 pwm low", 1'b0, 1'b0, 1'b0);
    settle();
    pulseStop();
    settle();
    @(negedge clk) pwmIn = 1'b1;
    expectOut("R10 stopped", 1'b0, 1'b1, 1'b0);
    settle();
    pulseStart();
    settle();
    expectOut("R10 restarted", 1'b1, 1'b0, 1'b0);
    settle();

    // R1 / R2: over-voltage
    @(negedge clk) ovpFlag = 1'b1;
    expectOut("R1 ovp immediate", 1'b0, 1'b1, 1'b0);
    doTicks(3);
    settle();
    expectOut("R2 three ticks", 1'b0, 1'b1, 1'b0);
    doTicks(1);
    settle();
    expectOut("R2 fourth tick latches", 1'b0, 1'b1, 1'b1);
    @(negedge clk) ovpFlag = 1'b0;
    settle();
    expectOut("R8 latched outputs", 1'b0, 1'b1, 1'b1);
    pulseStop();
    settle();
    pulseStart();
    settle();
    expectOut("R9 supply cycle keeps latch", 1'b0, 1'b1, 1'b1);
    clearLatch();
    expectOut("R9 standby clears", 1'b0, 1'b1, 1'b0);
    bringUp();
    expectOut("R9 back running", 1'b1, 1'b0, 1'b0);
    settle();

    // R5 / R3: LED over-current with a broken run
    @(negedge clk) ledOcFlag = 1'b1;
    doTicks(3);
    @(negedge clk) ledOcFlag = 1'b0;
    doTicks(1);
    @(negedge clk) ledOcFlag = 1'b1;
    doTicks(3);
    settle();
    expectOut("R5 broken run no latch", 1'b1, 1'b0, 1'b0);
    doTicks(1);
    settle();
    expectOut("R3 led oc latches", 1'b0, 1'b1, 1'b1);
    @(negedge clk) ledOcFlag = 1'b0;
    clearLatch();
    bringUp();

    // R4: hard over-current while gate is low
    @(negedge clk) pwmIn = 1'b0; hardOcFlag = 1'b1;
    doTicks(3);
    settle();
    expectOut("R4 three ticks gate low", 1'b0, 1'b0, 1'b0);
    doTicks(1);
    settle();
    expectOut("R4 hard oc latches", 1'b0, 1'b1, 1'b1);
    @(negedge clk) hardOcFlag = 1'b0; pwmIn = 1'b1;
    clearLatch();
    bringUp();

    // R11: standby low clears a partial run
    @(negedge clk) ovpFlag = 1'b1;
    doTicks(3);
    @(negedge clk) ovpFlag = 1'b0;
    clearLatch();
    bringUp();
    @(negedge clk) ovpFlag = 1'b1;
    doTicks(1);
    @(negedge clk) ovpFlag = 1'b0;
    settle();
    expectOut("R11 standby cleared count", 1'b1, 1'b0, 1'b0);
    doTicks(1);
    // R11: supply stop clears a partial run
    @(negedge clk) ovpFlag = 1'b1;
    doTicks(3);
    @(negedge clk) ovpFlag = 1'b0;
    pulseStop();
    settle();
    pulseStart();
    settle();
    @(negedge clk) ovpFlag = 1'b1;
    doTicks(1);
    @(negedge clk) ovpFlag = 1'b0;
    settle();
    expectOut("R11 supply stop cleared count", 1'b1, 1'b0, 1'b0);
    doTicks(1);

    // R6: no qualification before soft start or with pwm low
    @(negedge clk) fbMaxFlag = 1'b1; ssDone = 1'b0;
    doTicks(4 + CP_LIMIT + 2);
    settle();
    expectOut("R6 ignored before soft start", 1'b1, 1'b0, 1'b0);
    @(negedge clk) ssDone = 1'b1; pwmIn = 1'b0;
    doTicks(4 + CP_LIMIT + 2);
    settle();
    expectOut("R6 ignored with pwm low", 1'b0, 1'b0, 1'b0);
    // R6 / R7: qualify, then timer watches fbMax alone
    @(negedge clk) pwmIn = 1'b1;
    doTicks(4);
    @(negedge clk) pwmIn = 1'b0;
    doTicks(CP_LIMIT - 1);
    settle();
    expectOut("R7 timer one short", 1'b0, 1'b0, 1'b0);
    doTicks(1);
    settle();
    expectOut("R7 timer expiry latches", 1'b0, 1'b1, 1'b1);
    clearLatch();
    bringUp();

    // R7: dropping fbMax stops the timer
    @(negedge clk) pwmIn = 1'b1;
    doTicks(4);
    doTicks(CP_LIMIT - 1);
    @(negedge clk) fbMaxFlag = 1'b0;
    doTicks(1);
    @(negedge clk) fbMaxFlag = 1'b1; pwmIn = 1'b0;
    doTicks(CP_LIMIT + 2);
    settle();
    expectOut("R7 drop clears timer", 1'b0, 1'b0, 1'b0);
    @(negedge clk) pwmIn = 1'b1;
    doTicks(3);
    settle();
    expectOut("R6 requalify needs four", 1'b1, 1'b0, 1'b0);
    @(negedge clk) fbMaxFlag = 1'b0; ssDone = 1'b0;
    settle();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule